// File: doc/BRIEF.md
# Parity-Protected Instruction Store Writer

This block is the host-side write path into a small engine's instruction store. Each stored word is 42 bits wide: a 40-bit instruction plus two even-parity bits that the block generates itself. The host sets an index register, with a program-mode flag in its top bit. It then writes each instruction as two 32-bit halves. The low half is only held in a register. Writing the high half commits the whole word and steps the index forward by one. After the last entry of the store the index wraps to zero.

A fetch port reads one word per request and presents it a cycle later. When store checking is enabled through a control register, the block recomputes both parities on every fetched word. On any mismatch it raises a sticky error flag. A two-bit error-injection input flips the generated parity bits of a committing word, so the error path can be exercised.

Top module: `cstore_writer`

## Requirements
- R1: After synchronous reset the index is 0, program mode and checking are off, `par_err` and `fetch_valid` are 0, and reads of the index register (offset 0x000) and the control register (offset 0x018) return 0.
- R2: A write to offset 0x000 loads program mode from data bit 31 and the index from the low index bits. Writing 0 ends programming. A read of 0x000 returns {mode, zeros, index} on `csr_rdata` one cycle after the read strobe.
- R3: A write to offset 0x004 only holds the low 32 instruction bits. A write to offset 0x008 in program mode commits {parity, data[7:0], low word} at the current index and advances the index by one.
- R4: A commit at index DEPTH-1 wraps the index to 0, so a read of 0x000 then returns 0x80000000.
- R5: Stored bit 40 is the XOR of instruction bits 19:0, and stored bit 41 is the XOR of bits 39:20. Data bits 31:8 of the upper write, including any parity the host tries to supply in bits 9:8, are ignored.
- R6: With `fetch_en` high at a clock edge, `fetch_insn` holds the 42-bit word at `fetch_addr` from that edge on, with `fetch_valid` high for one cycle.
- R7: Writes to 0x004 or 0x008 outside program mode change neither the store nor the index.
- R8: Bit 28 of the control register at offset 0x018 enables store checking. It reads back at bit 28, and the other bits read as 0.
- R9: With checking enabled, a valid fetched word whose stored parity bits disagree with the recomputed ones sets `par_err` at the next edge. The flag then stays high until reset. With checking disabled it is never set.
- R10: `err_inject[0]` and `err_inject[1]` invert stored bits 40 and 41, respectively, of a word committed in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr | input | 1 | Register write strobe |
| csr_rd | input | 1 | Register read strobe |
| csr_addr | input | 10 | Register byte offset |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Registered read data |
| err_inject | input | 2 | Parity flip for the committing word (bit 0 → bit 40, bit 1 → bit 41) |
| fetch_en | input | 1 | Fetch request |
| fetch_addr | input | IDX_W | Fetch index |
| fetch_insn | output | 42 | Fetched word with parity |
| fetch_valid | output | 1 | Fetched word valid |
| par_err | output | 1 | Sticky parity-error flag |

## Verification
The assertions assume the host issues at most one register strobe per cycle and drives `csr_addr` to a known value whenever a strobe is high. They also assume fetches go only to entries that were written since power-up, because store contents are not reset. The directed tasks keep to both rules. Each task issues single-strobe accesses separated by idle cycles, and it fetches only indices it has committed earlier in the same run. `err_inject` is driven only during an upper-word write, and it is held at zero otherwise.

// File: rtl/csw_pkg.sv
package csw_pkg;
    localparam int INSN_W  = 40;
    localparam int WORD_W  = 42;
    localparam int OFS_W   = 10;
    localparam int MODE_BIT = 31;
    localparam int CHK_BIT  = 28;
    localparam logic [OFS_W-1:0] OFS_INDEX = 10'h000;
    localparam logic [OFS_W-1:0] OFS_LOW   = 10'h004;
    localparam logic [OFS_W-1:0] OFS_HIGH  = 10'h008;
    localparam logic [OFS_W-1:0] OFS_CTRL  = 10'h018;

    typedef struct packed {
        logic              par_hi;
        logic              par_lo;
        logic [INSN_W-1:0] insn;
    } cs_word_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_INDEX,
        SEL_LOW,
        SEL_HIGH,
        SEL_CTRL
    } csr_sel_e;

    function automatic csr_sel_e decode_ofs(input logic [OFS_W-1:0] ofs);
        case (ofs)
            OFS_INDEX: return SEL_INDEX;
            OFS_LOW:   return SEL_LOW;
            OFS_HIGH:  return SEL_HIGH;
            OFS_CTRL:  return SEL_CTRL;
            default:   return SEL_NONE;
        endcase
    endfunction

    // {upper-half parity, lower-half parity}, each making its half even
    function automatic logic [1:0] half_parity(input logic [INSN_W-1:0] v);
        return {^v[39:20], ^v[19:0]};
    endfunction

    function automatic cs_word_t seal_word(input logic [INSN_W-1:0] v,
                                           input logic [1:0] flip);
        logic [1:0] p;
        p = half_parity(v) ^ flip;
        return '{par_hi: p[1], par_lo: p[0], insn: v};
    endfunction
endpackage

// File: rtl/cs_csr_regs.sv
module cs_csr_regs
    import csw_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csr_wr,
    input  logic              csr_rd,
    input  logic [OFS_W-1:0]  csr_addr,
    input  logic [31:0]       csr_wdata,
    output logic [31:0]       csr_rdata,
    output logic              commit,
    output logic [IDX_W-1:0]  commit_idx,
    output logic [INSN_W-1:0] commit_insn,
    output logic              chk_en
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    csr_sel_e         sel;
    logic             prog_mode;
    logic [IDX_W-1:0] idx;
    logic [31:0]      low_hold;
    logic [IDX_W-1:0] idx_next;

    assign sel         = decode_ofs(csr_addr);
    assign commit      = csr_wr && (sel == SEL_HIGH) && prog_mode;
    assign commit_idx  = idx;
    assign commit_insn = {csr_wdata[7:0], low_hold};
    assign idx_next    = (idx == LAST_IDX) ? '0 : idx + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            prog_mode <= 1'b0;
            idx       <= '0;
            low_hold  <= '0;
            chk_en    <= 1'b0;
        end else if (csr_wr) begin
            case (sel)
                SEL_INDEX: begin
                    prog_mode <= csr_wdata[MODE_BIT];
                    idx       <= csr_wdata[IDX_W-1:0];
                end
                SEL_LOW:  if (prog_mode) low_hold <= csr_wdata;
                SEL_HIGH: if (prog_mode) idx <= idx_next;
                SEL_CTRL: chk_en <= csr_wdata[CHK_BIT];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            csr_rdata <= '0;
        end else if (csr_rd) begin
            case (sel)
                SEL_INDEX: begin
                    csr_rdata <= '0;
                    csr_rdata[MODE_BIT] <= prog_mode;
                    csr_rdata[IDX_W-1:0] <= idx;
                end
                SEL_LOW:  csr_rdata <= low_hold;
                SEL_CTRL: begin
                    csr_rdata <= '0;
                    csr_rdata[CHK_BIT] <= chk_en;
                end
                default:  csr_rdata <= '0;
            endcase
        end
    end

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
        (commit && idx != LAST_IDX) |=> (idx == $past(idx) + 1'b1)) // R3
        else $error("index did not advance");
    AST_IDX_WRAP: assert property (@(posedge clk) disable iff (rst)
        (commit && idx == LAST_IDX) |=> (idx == '0 && prog_mode)) // R4
        else $error("index did not wrap");
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (csr_wr && !prog_mode && (sel == SEL_LOW || sel == SEL_HIGH)) |=> $stable(idx) && $stable(low_hold)) // R7
        else $error("data write outside program mode took effect");
endmodule

// File: rtl/cs_store_mem.sv
module cs_store_mem
    import csw_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  cs_word_t         wr_word,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output cs_word_t         rd_word,
    output logic             rd_valid
);
    cs_word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_word;
    end

    always_ff @(posedge clk) begin
        if (rd_en) rd_word <= mem[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) rd_valid <= 1'b0;
        else     rd_valid <= rd_en;
    end

    AST_RD_PULSE: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid) // R6
        else $error("valid without a fetch");
endmodule

// File: rtl/cs_parity_mon.sv
module cs_parity_mon
    import csw_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     chk_en,
    input  logic     word_valid,
    input  cs_word_t word,
    output logic     par_err
);
    logic mismatch;

    assign mismatch = half_parity(word.insn) != {word.par_hi, word.par_lo};

    always_ff @(posedge clk) begin
        if (rst)                                   par_err <= 1'b0;
        else if (chk_en && word_valid && mismatch) par_err <= 1'b1;
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        par_err |=> par_err) // R9
        else $error("parity flag dropped");
    AST_ERR_GATED: assert property (@(posedge clk) disable iff (rst)
        (!par_err && !chk_en) |=> !par_err) // R9
        else $error("parity flag set while checking off");
endmodule

// File: rtl/cstore_writer.sv
module cstore_writer
    import csw_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csr_wr,
    input  logic              csr_rd,
    input  logic [OFS_W-1:0]  csr_addr,
    input  logic [31:0]       csr_wdata,
    output logic [31:0]       csr_rdata,
    input  logic [1:0]        err_inject,
    input  logic              fetch_en,
    input  logic [IDX_W-1:0]  fetch_addr,
    output logic [WORD_W-1:0] fetch_insn,
    output logic              fetch_valid,
    output logic              par_err
);
    logic              commit;
    logic [IDX_W-1:0]  commit_idx;
    logic [INSN_W-1:0] commit_insn;
    logic              chk_en;
    cs_word_t          wr_word;
    cs_word_t          rd_word;

    assign wr_word    = seal_word(commit_insn, err_inject);
    assign fetch_insn = rd_word;

    cs_csr_regs #(.DEPTH(DEPTH)) u_regs (
        .clk(clk), .rst(rst),
        .csr_wr(csr_wr), .csr_rd(csr_rd), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .commit(commit), .commit_idx(commit_idx),
        .commit_insn(commit_insn), .chk_en(chk_en)
    );

    cs_store_mem #(.DEPTH(DEPTH)) u_mem (
        .clk(clk), .rst(rst),
        .wr_en(commit), .wr_idx(commit_idx), .wr_word(wr_word),
        .rd_en(fetch_en), .rd_idx(fetch_addr),
        .rd_word(rd_word), .rd_valid(fetch_valid)
    );

    cs_parity_mon u_mon (
        .clk(clk), .rst(rst), .chk_en(chk_en),
        .word_valid(fetch_valid), .word(rd_word), .par_err(par_err)
    );

    AST_SEAL_EVEN: assert property (@(posedge clk) disable iff (rst)
        (commit && err_inject == 2'b00) |->
        (^wr_word[19:0] == wr_word.par_lo && ^wr_word[39:20] == wr_word.par_hi)) // R5
        else $error("committed word parity wrong");
    AST_NO_COMMIT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !csr_wr |-> !commit) // R7
        else $error("commit without a write");
endmodule

// File: tb/cstore_writer_tb.sv
module cstore_writer_tb;
    localparam int DEPTH = 1024;
    localparam int IDX_W = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst;
    logic              csr_wr, csr_rd;
    logic [9:0]        csr_addr;
    logic [31:0]       csr_wdata, csr_rdata;
    logic [1:0]        err_inject;
    logic              fetch_en;
    logic [IDX_W-1:0]  fetch_addr;
    logic [41:0]       fetch_insn;
    logic              fetch_valid, par_err;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    cstore_writer #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .csr_wr(csr_wr), .csr_rd(csr_rd),
        .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .err_inject(err_inject), .fetch_en(fetch_en), .fetch_addr(fetch_addr),
        .fetch_insn(fetch_insn), .fetch_valid(fetch_valid), .par_err(par_err)
    );

    function automatic logic [41:0] model(input logic [31:0] lo, input logic [31:0] hi,
                                          input logic [1:0] flip);
        logic [39:0] v;
        v = {hi[7:0], lo};
        return {(^v[39:20]) ^ flip[1], (^v[19:0]) ^ flip[0], v};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d, input logic [1:0] inj = 2'b00);
        @(negedge clk);
        csr_wr = 1'b1; csr_addr = a; csr_wdata = d; err_inject = inj;
        @(negedge clk);
        csr_wr = 1'b0; err_inject = 2'b00;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        csr_rd = 1'b1; csr_addr = a;
        @(negedge clk);
        csr_rd = 1'b0;
        d = csr_rdata;
    endtask

    task automatic fetch(input int idx, output logic [41:0] w, output logic v);
        @(negedge clk);
        fetch_en = 1'b1; fetch_addr = IDX_W'(idx);
        @(negedge clk);
        fetch_en = 1'b0;
        w = fetch_insn; v = fetch_valid;
    endtask

    task automatic put(input logic [31:0] lo, input logic [31:0] hi, input logic [1:0] inj = 2'b00);
        wr(10'h004, lo);
        wr(10'h008, hi, inj);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 par_err", 64'(par_err), 64'd0);
        check("R1 fetch_valid", 64'(fetch_valid), 64'd0);
        rd(10'h000, d); check("R1 index reg", 64'(d), 64'd0);
        rd(10'h018, d); check("R1 ctrl reg", 64'(d), 64'd0);
    endtask

    task automatic t_program();
        logic [31:0] d; logic [41:0] w; logic v;
        wr(10'h000, 32'h8000_0005);
        rd(10'h000, d); check("R2 index load", 64'(d), 64'h8000_0005);
        put(32'h1234_5678, 32'h0000_00a5);
        put(32'hdead_beef, 32'hffff_ff3c);      // R5 host bits 31:8 ignored
        rd(10'h000, d); check("R3 index advanced", 64'(d), 64'h8000_0007);
        fetch(5, w, v);
        check("R6 valid", 64'(v), 64'd1);
        check("R3 word 5", 64'(w), 64'(model(32'h1234_5678, 32'ha5, 2'b00)));
        fetch(6, w, v);
        check("R5 word 6 parity", 64'(w), 64'(model(32'hdead_beef, 32'h3c, 2'b00)));
        @(negedge clk);
        check("R6 valid one cycle", 64'(fetch_valid), 64'd0);
    endtask

    task automatic t_idle_writes();
        logic [31:0] d; logic [41:0] w; logic v;
        wr(10'h000, 32'h0000_0005);
        put(32'h0bad_0bad, 32'h0000_0077);
        rd(10'h000, d); check("R7 index unchanged", 64'(d), 64'h0000_0005);
        fetch(5, w, v);
        check("R7 store unchanged", 64'(w), 64'(model(32'h1234_5678, 32'ha5, 2'b00)));
        wr(10'h000, 32'h0);
        rd(10'h000, d); check("R2 end programming", 64'(d), 64'h0);
    endtask

    task automatic t_wrap();
        logic [31:0] d; logic [41:0] w; logic v;
        wr(10'h000, 32'h8000_0000 | 32'(DEPTH - 2));
        put(32'h0000_0001, 32'h0000_0000);
        put(32'h000f_ffff, 32'h0000_0080);
        rd(10'h000, d); check("R4 wrap readback", 64'(d), 64'h8000_0000);
        put(32'h00_0c0300, 32'h0000_00f0);        // no-op pattern lands at 0
        rd(10'h000, d); check("R4 after wrap", 64'(d), 64'h8000_0001);
        fetch(DEPTH - 1, w, v);
        check("R4 last entry", 64'(w), 64'(model(32'h000f_ffff, 32'h80, 2'b00)));
        fetch(0, w, v);
        check("R5 no-op word", 64'(w), 64'(model(32'h000c_0300, 32'hf0, 2'b00)));
        wr(10'h000, 32'h0);
    endtask

    task automatic t_parity_check();
        logic [31:0] d; logic [41:0] w; logic v;
        wr(10'h000, 32'h8000_000a);
        put(32'h5555_aaaa, 32'h0000_0011, 2'b01);
        put(32'h0000_0003, 32'h0000_0000, 2'b10);
        wr(10'h000, 32'h0);
        fetch(10, w, v);
        check("R10 flip bit40", 64'(w), 64'(model(32'h5555_aaaa, 32'h11, 2'b01)));
        @(negedge clk);
        check("R9 disabled no flag", 64'(par_err), 64'd0);
        wr(10'h018, 32'hffff_ffff);
        rd(10'h018, d); check("R8 ctrl readback", 64'(d), 64'h1000_0000);
        fetch(5, w, v);
        @(negedge clk);
        check("R9 good word no flag", 64'(par_err), 64'd0);
        fetch(11, w, v);
        check("R10 flip bit41", 64'(w), 64'(model(32'h3, 32'h0, 2'b10)));
        @(negedge clk);
        check("R9 flag set", 64'(par_err), 64'd1);
        wr(10'h018, 32'h0);
        fetch(5, w, v);
        @(negedge clk);
        check("R9 sticky", 64'(par_err), 64'd1);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_cmp++; n_bad++;
                $display("FAIL watchdog actual=%0d expected<=100000", cycles);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    initial begin
        rst = 1'b1; csr_wr = 0; csr_rd = 0; csr_addr = 0; csr_wdata = 0;
        err_inject = 0; fetch_en = 0; fetch_addr = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_program();
        t_idle_writes();
        t_wrap();
        t_parity_check();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule